// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block acts as the memory side of a small two-wire serial EEPROM. It samples the shared clock and data lines with the system clock. It pulls the data line low only through an open-drain enable, and it holds a byte-wide storage array that comes up at 0xFF after reset. The block finds bus start and stop conditions and answers only to its own device address. In a write, it takes one word-address byte and then data bytes. Those data bytes are collected in a one-page staging buffer, and the array is changed only when a stop condition ends the write.

A stop that closes a write carrying data starts a programming window of a set number of clocks. During that window the device address is not acknowledged, so a master can poll until the write is finished. Reads come in three forms. A current-address read uses the internal counter. A random read first loads the counter with an address-only write phase and a repeated start. A sequential read keeps returning bytes for as long as the master acknowledges them.

Top module: `eeprom_slave`

## Requirements
- R1: After reset, the data-line pull-down is released and every array byte reads back as 0xFF.
- R2: A device address byte is accepted only when bits 7:4 are 1010 and bits 3:1 match `strap_i`. Bit 0 selects the direction, with 0 meaning write. Any other address gets no acknowledge, and both the array and the address counter stay unchanged.
- R3: The slave pulls SDA low during the ninth clock after a matching device address, after the word address, and after every data byte it receives in a write. It changes the pull-down only while SCL is low.
- R4: Received data bytes go into the array only when a STOP ends the write. If a repeated START arrives before that STOP, the staged bytes are discarded.
- R5: Each data byte in a write advances only the low log2(PAGE_BYTES) bits of the address counter. The upper bits stay fixed, so bytes beyond one page wrap and overwrite earlier bytes of the same page.
- R6: A STOP that ends a write carrying at least one data byte makes the device address go unacknowledged for BUSY_CYCLES clocks. After that window the device address is acknowledged again.
- R7: A random read (write-direction address phase with a word address and no data, repeated START, read-direction address) returns the byte stored at that word address.
- R8: A current-address read starts at the counter left by the last access. After a write, that is one past the last written byte, wrapped within its page. After a read, it is one past the last byte sent.
- R9: In a read, each byte sent advances the full address counter, which wraps from the last array address to 0. The slave keeps sending bytes while the master acknowledges them.
- R10: After the master answers a byte with no acknowledge, the slave releases SDA and drives nothing until the next START.
- R11: Writing an address that already holds data replaces the old contents with no erase step.
- R12: A write transaction that carries only a word address and then a STOP starts no programming window, so the device address is acknowledged immediately afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Level of the bus clock line |
| sda_i | input | 1 | Level of the bus data line, as seen on the wired bus |
| strap_i | input | 3 | Board-set low bits of the device address |
| sda_oe | output | 1 | When high, the slave pulls the data line low |

## Verification
The bench writes 20 bytes into one 16-byte page. A counter that carried into the upper bits would corrupt the neighbouring page, and a counter that never wrapped would leave the first four bytes holding their old values. It polls the device address right after a STOP and again after the programming window. A busy timer that was missing, started too late or never ended shows up as a wrong acknowledge. It also separates an address-only write from a real one, and it checks that a repeated START throws away staged bytes. Random-length sequential reads cross the 0xFF to 0x00 boundary, and current-address reads follow writes, random reads and a mismatched-address attempt. Both catch a counter that wraps at the page boundary on reads or that moves when it should not.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WORD,
    ST_WDATA,
    ST_RDATA,
    ST_MACK,
    ST_ACK
  } phase_t;

  localparam logic [3:0] DEV_FAMILY = 4'b1010;

  // Device address byte: family in [7:4], strap copy in [3:1], direction in [0]
  function automatic logic dev_match(input logic [7:0] b, input logic [2:0] strap);
    return (b[7:4] == DEV_FAMILY) && (b[3:1] == strap);
  endfunction

endpackage

// File: rtl/eeprom_line_monitor.sv
module eeprom_line_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic scl_m, scl_s, scl_p;
  logic sda_m, sda_s, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_p <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_p <= scl_s;
      sda_m <= sda_i; sda_s <= sda_m; sda_p <= sda_s;
    end
  end

  assign scl_lvl  = scl_s;
  assign sda_lvl  = sda_s;
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  // data edges while the clock stays high mark frame boundaries
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/eeprom_busy_timer.sv
module eeprom_busy_timer #(
  parameter int BUSY_CYCLES = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  output logic busy_o
);

  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      remain <= '0;
    else if (launch_i)
      remain <= CW'(BUSY_CYCLES);
    else if (remain != '0)
      remain <= remain - CW'(1);
  end

  assign busy_o = (remain != '0);

  assert_busy_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |=> busy_o);

  assert_busy_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    remain <= CW'(BUSY_CYCLES));

endmodule

// File: rtl/eeprom_page_store.sv
module eeprom_page_store #(
  parameter int MEM_BYTES  = 256,
  parameter int PAGE_BYTES = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear_i,
  input  logic                         wr_en_i,
  input  logic [$clog2(MEM_BYTES)-1:0] wr_addr_i,
  input  logic [7:0]                   wr_data_i,
  input  logic                         commit_i,
  input  logic [$clog2(MEM_BYTES)-1:0] rd_addr_i,
  output logic [7:0]                   rd_data_o,
  output logic                         commit_fire_o
);

  localparam int AW = $clog2(MEM_BYTES);
  localparam int OW = $clog2(PAGE_BYTES);
  localparam int BW = AW - OW;

  logic [7:0]            mem  [MEM_BYTES];
  logic [7:0]            pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid;
  logic [BW-1:0]         base;

  assign commit_fire_o = commit_i && (valid != '0);

  // staging buffer: one slot per page offset, last write to a slot wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= '0;
      base  <= '0;
      for (int k = 0; k < PAGE_BYTES; k++) pbuf[k] <= 8'h00;
    end else if (clear_i || commit_i) begin
      valid <= '0;
    end else if (wr_en_i) begin
      pbuf[wr_addr_i[OW-1:0]]  <= wr_data_i;
      valid[wr_addr_i[OW-1:0]] <= 1'b1;
      base                     <= wr_addr_i[AW-1:OW];
    end
  end

  // array: erased state after reset, whole page programmed at commit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (commit_fire_o) begin
      for (int j = 0; j < PAGE_BYTES; j++)
        if (valid[j]) mem[{base, OW'(j)}] <= pbuf[j];
    end
  end

  assign rd_data_o = mem[rd_addr_i];

endmodule

// File: rtl/eeprom_slave.sv
module eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int MEM_BYTES   = 256,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe
);

  localparam int AW = $clog2(MEM_BYTES);
  localparam int OW = $clog2(PAGE_BYTES);

  // write pointer: only the in-page offset moves
  function automatic logic [AW-1:0] page_step(input logic [AW-1:0] a);
    logic [OW-1:0] off;
    off = a[OW-1:0] + OW'(1);
    return {a[AW-1:OW], off};
  endfunction

  // read pointer: whole counter moves, wraps at the array end
  function automatic logic [AW-1:0] seq_step(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic busy, commit_fire;
  logic [7:0] rd_data;

  phase_t        phase, after_ack;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg;
  logic [AW-1:0] addr_ctr;
  logic          sda_oe_q;
  logic          mack_more;
  logic [2:0]    tx_idx;

  eeprom_line_monitor u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  // named internal events
  logic byte_in_done, dev_done, dev_hit, word_done, wdata_done, mack_sample;
  assign byte_in_done = scl_fall && (bitcnt == 4'd8) &&
                        (phase == ST_DEV || phase == ST_WORD || phase == ST_WDATA);
  assign dev_done     = byte_in_done && (phase == ST_DEV);
  assign dev_hit      = dev_match(shreg, strap_i) && !busy;
  assign word_done    = byte_in_done && (phase == ST_WORD);
  assign wdata_done   = byte_in_done && (phase == ST_WDATA);
  assign mack_sample  = scl_rise && (phase == ST_MACK);
  assign tx_idx       = 3'(4'd7 - bitcnt);

  eeprom_page_store #(
    .MEM_BYTES  (MEM_BYTES),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_store (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear_i       (start_ev),
    .wr_en_i       (wdata_done),
    .wr_addr_i     (addr_ctr),
    .wr_data_i     (shreg),
    .commit_i      (stop_ev),
    .rd_addr_i     (addr_ctr),
    .rd_data_o     (rd_data),
    .commit_fire_o (commit_fire)
  );

  eeprom_busy_timer #(
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_busy (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch_i (commit_fire),
    .busy_o   (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= ST_IDLE;
      after_ack <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      addr_ctr  <= '0;
      sda_oe_q  <= 1'b0;
      mack_more <= 1'b0;
    end else if (start_ev) begin
      phase    <= ST_DEV;
      bitcnt   <= '0;
      sda_oe_q <= 1'b0;
    end else if (stop_ev) begin
      phase    <= ST_IDLE;
      sda_oe_q <= 1'b0;
    end else begin
      case (phase)
        ST_DEV, ST_WORD, ST_WDATA: begin
          if (scl_rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda_lvl};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_in_done) begin
            if (phase == ST_DEV) begin
              if (dev_hit) begin
                sda_oe_q  <= 1'b1;
                phase     <= ST_ACK;
                after_ack <= shreg[0] ? ST_RDATA : ST_WORD;
              end else begin
                phase <= ST_IDLE;
              end
            end else if (phase == ST_WORD) begin
              sda_oe_q  <= 1'b1;
              phase     <= ST_ACK;
              after_ack <= ST_WDATA;
              addr_ctr  <= shreg[AW-1:0];
            end else begin
              sda_oe_q  <= 1'b1;
              phase     <= ST_ACK;
              after_ack <= ST_WDATA;
              addr_ctr  <= page_step(addr_ctr);
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bitcnt   <= '0;
            phase    <= after_ack;
            sda_oe_q <= (after_ack == ST_RDATA) ? ~rd_data[7] : 1'b0;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe_q <= 1'b0;
              phase    <= ST_MACK;
            end else begin
              sda_oe_q <= ~rd_data[tx_idx];
            end
          end
        end
        ST_MACK: begin
          if (mack_sample) begin
            mack_more <= !sda_lvl;
            addr_ctr  <= seq_step(addr_ctr);
          end else if (scl_fall) begin
            if (mack_more) begin
              phase    <= ST_RDATA;
              bitcnt   <= '0;
              sda_oe_q <= ~rd_data[7];
            end else begin
              phase <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = sda_oe_q;

  assert_oe_moves_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_q) |-> !scl_lvl);

  assert_no_ack_foreign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_done && !dev_match(shreg, strap_i)) |=> !sda_oe_q);

  assert_busy_nak_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_done && busy) |=> !sda_oe_q);

  assert_page_upper_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wdata_done |=> addr_ctr[AW-1:OW] == $past(addr_ctr[AW-1:OW]));

  assert_release_on_nak_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mack_sample && sda_lvl) |=> !sda_oe_q);

  assert_stop_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (phase == ST_IDLE) && !sda_oe_q);

endmodule

// File: tb/eeprom_slave_bench.sv
module eeprom_slave_bench;

  localparam int MEM  = 256;
  localparam int PAGE = 16;
  localparam int BUSY = 500;
  localparam int Q    = 6;

  logic       clk   = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl   = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  wire        sda_oe;
  wire        sda_bus = sda_m & ~sda_oe;

  eeprom_slave #(.MEM_BYTES(MEM), .PAGE_BYTES(PAGE), .BUSY_CYCLES(BUSY)) u_eeprom_slave (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl),
    .sda_i   (sda_bus),
    .strap_i (strap),
    .sda_oe  (sda_oe)
  );

  always #4 clk = ~clk;

  int         checks = 0;
  int         errors = 0;
  bit         done   = 0;
  logic [7:0] bm   [MEM];
  logic [7:0] wdat [32];
  logic [7:0] bctr;

  function automatic logic [7:0] pg_next(input logic [7:0] a);
    return (a & 8'hF0) | ((a + 8'd1) & 8'h0F);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart;
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bstop;
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    ack = !sda_bus;
    tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1'b1; tick(Q); b[i] = sda_bus; tick(Q); scl = 1'b0;
    end
    tick(Q); sda_m = !mack; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic dev(input bit rd, input bit exp_ack, input string tag);
    bit ack;
    send_byte({4'b1010, strap, rd}, ack);
    check(ack == exp_ack, tag, ack, exp_ack);
  endtask

  // full write transaction from wdat[0..n-1]; model applies at STOP
  task automatic do_write(input logic [7:0] wa, input int n, input string tag);
    bit ack;
    logic [7:0] a;
    bstart;
    dev(1'b0, 1'b1, "R3 dev ack write");
    send_byte(wa, ack);
    check(ack, "R3 word ack", ack, 1);
    a = wa;
    for (int k = 0; k < n; k++) begin
      send_byte(wdat[k], ack);
      check(ack, tag, ack, 1);
      bm[a] = wdat[k];
      a = pg_next(a);
    end
    bstop;
    bctr = a;
  endtask

  task automatic read_body(input logic [7:0] a0, input int n, input string tag);
    logic [7:0] a, got;
    a = a0;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, got);
      check(got == bm[a], tag, got, bm[a]);
      a = a + 8'd1;
    end
    bstop;
    bctr = a;
  endtask

  task automatic do_rand_read(input logic [7:0] wa, input int n, input string tag);
    bit ack;
    bstart;
    dev(1'b0, 1'b1, "R7 dev ack dummy write");
    send_byte(wa, ack);
    check(ack, "R7 word ack", ack, 1);
    bstart;
    dev(1'b1, 1'b1, "R7 dev ack read");
    read_body(wa, n, tag);
  endtask

  task automatic do_cur_read(input int n, input string tag);
    bstart;
    dev(1'b1, 1'b1, "R8 dev ack current read");
    read_body(bctr, n, tag);
  endtask

  task automatic wait_prog;
    tick(BUSY + 20);
  endtask

  initial begin
    bit ack;
    logic [7:0] got;
    for (int i = 0; i < MEM; i++) bm[i] = 8'hFF;
    bctr = 8'h00;
    void'($urandom(32'h5EED_1234));
    tick(10);
    check(sda_oe == 1'b0, "R1 sda released in reset", sda_oe, 0);
    rst_n = 1'b1;
    tick(10);
    check(sda_oe == 1'b0, "R1 sda released after reset", sda_oe, 0);
    do_rand_read(8'h00, 4, "R1 erased contents");

    // page wrap: 20 bytes at offset 0xC of page 0x30
    for (int k = 0; k < 20; k++) wdat[k] = 8'h10 + 8'(k);
    do_write(8'h3C, 20, "R5 data ack");
    bstart; dev(1'b0, 1'b0, "R6 nak while programming"); bstop;
    wait_prog;
    bstart; dev(1'b0, 1'b1, "R6 ack after window");
    send_byte(8'h00, ack); bstop;
    bctr = 8'h00;
    bstart; dev(1'b0, 1'b1, "R12 no window after address-only write"); bstop;
    do_rand_read(8'h2F, 18, "R5 page wrap contents");

    // foreign addresses leave the counter alone
    do_rand_read(8'h35, 1, "R7 single random read");
    bstart; send_byte({4'b1010, 3'b010, 1'b0}, ack);
    check(!ack, "R2 wrong strap nak", ack, 0); bstop;
    bstart; send_byte({4'b0110, strap, 1'b1}, ack);
    check(!ack, "R2 wrong family nak", ack, 0); bstop;
    do_cur_read(1, "R2 counter unchanged");

    // staged bytes dropped by repeated START
    bstart; dev(1'b0, 1'b1, "R4 dev ack");
    send_byte(8'h80, ack);
    for (int k = 0; k < 3; k++) begin
      send_byte(8'hA0 + 8'(k), ack);
      check(ack, "R3 data ack", ack, 1);
    end
    bstart; dev(1'b0, 1'b1, "R4 no window after discard");
    send_byte(8'h80, ack);
    bstart; dev(1'b1, 1'b1, "R4 read ack");
    read_body(8'h80, 3, "R4 discarded bytes absent");

    // overwrite without erase
    wdat[0] = 8'h5A; do_write(8'h47, 1, "R11 first write"); wait_prog;
    wdat[0] = 8'hC3; do_write(8'h47, 1, "R11 second write"); wait_prog;
    do_rand_read(8'h47, 1, "R11 replaced value");

    // current read after a page-wrapping write
    for (int k = 0; k < 3; k++) wdat[k] = 8'h70 + 8'(k);
    do_write(8'h9E, 3, "R5 data ack"); wait_prog;
    do_cur_read(2, "R8 counter after write");

    // sequential read across the array end
    wdat[0] = 8'hE1; wdat[1] = 8'hE2;
    do_write(8'hFE, 2, "R3 data ack"); wait_prog;
    do_rand_read(8'hFE, 4, "R9 wrap at array end");

    // NAK then extra clocks: slave stays silent
    bstart; dev(1'b1, 1'b1, "R10 dev ack");
    recv_byte(1'b0, got);
    check(got == bm[bctr], "R10 byte before nak", got, bm[bctr]);
    bctr = bctr + 8'd1;
    for (int p = 0; p < 9; p++) begin
      tick(Q); scl = 1'b1; tick(Q);
      check(sda_bus == 1'b1, "R10 line released after nak", sda_bus, 1);
      tick(Q); scl = 1'b0; tick(Q);
    end
    bstop;
    do_cur_read(2, "R9 counter after nak");

    // random traffic
    for (int t = 0; t < 8; t++) begin
      logic [7:0] wa;
      int n;
      wa = 8'($urandom % 256);
      n  = 1 + int'($urandom % 20);
      for (int k = 0; k < n; k++) wdat[k] = 8'($urandom);
      do_write(wa, n, "R5 random write ack");
      wait_prog;
      do_cur_read(1 + int'($urandom % 4), "R8 random current read");
      do_rand_read(8'($urandom % 256), 1 + int'($urandom % 20), "R9 random sequential read");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule